// File: doc/BRIEF.md
# Sync-Pulse Trigger-Clock Phase Meter

This block runs in a device's sample-clock domain. It produces a local trigger clock by dividing the sample clock, and it measures where that trigger clock sits relative to a slow reference clock that all devices share. One device drives a shared sync pulse while the shared clock is high. Every device that is armed sees the pulse, waits for the next rising edge of the shared clock, and counts sample cycles from that edge to the next rising edge of its own trigger clock. Because all devices use the same shared-clock edge, the difference between one device's count and a chosen reference device's count is the alignment error between them. The shared clock and the pulse are asynchronous to the sample clock; each passes through a two-flop synchronizer, and shared-clock rising edges are found by comparing the synchronized value with its previous value.

The count is latched together with a done flag. If no trigger-clock rising edge arrives within one full trigger-clock period, a timeout flag is raised instead. The result is held until it is acknowledged, and only then is the block armed again; a pulse that arrives while the block is not armed has no effect. A separate strobe with a signed amount moves the trigger-clock divider by that many sample cycles, modulo the division ratio, so that software can correct the measured error.

Top module: `sync_phase_meter`

## Requirements
- R1: After reset, armed is 1, measDone and measTimeout are 0, measCount is 0, the divider phase is 0 and trigClk is 1.
- R2: Without a shift strobe, the divider phase advances by one per sample cycle modulo DIV (default 8); trigClk is 1 while the phase is below DIV/2 and 0 otherwise.
- R3: In a cycle with shiftStb high, the divider phase advances by 1 + shiftAmt (signed two's complement) modulo DIV, with the result in the range 0 to DIV-1; each strobe cycle applies the amount once.
- R4: syncClkAsync and syncPulseAsync each pass through two sample-clock flops; a synchronized pulse seen while armed makes armed drop on the next cycle, and the block then waits for a synchronized rising edge of the shared clock.
- R5: The count starts in the cycle where that rising edge is detected. When trigClk first goes from 0 to 1 in a later cycle, measCount becomes the number of cycles from the detection cycle to that cycle (1 to DIV), and measDone is set.
- R6: While readAck is low, measDone, measTimeout and measCount hold their values.
- R7: If DIV cycles after detection pass with no trigClk rising edge, measTimeout is set and measCount is 0.
- R8: readAck while a result is held clears both flags and measCount, and sets armed on the next cycle; readAck while armed or waiting has no effect.
- R9: A sync pulse that arrives while the block is waiting, counting or holding a result is ignored.
- R10: measDone and measTimeout are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncClkAsync | input | 1 | Shared slow reference clock, asynchronous |
| syncPulseAsync | input | 1 | Shared sync pulse, asynchronous |
| shiftStb | input | 1 | Apply one divider phase shift this cycle |
| shiftAmt | input | SHIFT_W | Signed shift in sample cycles |
| readAck | input | 1 | Acknowledge the held result and re-arm |
| trigClk | output | 1 | Divided trigger clock |
| armed | output | 1 | Ready to accept a sync pulse |
| measDone | output | 1 | A count is held in measCount |
| measTimeout | output | 1 | No trigger-clock edge within one period |
| measCount | output | CNT_W | Cycles from shared-clock edge to trigger-clock edge |

## Verification
The assertions assume that readAck is raised only as a single-cycle pulse once a result is held, and that the shared clock is slow enough for the synchronizers to report each of its levels for several cycles. The stimulus raises the sync pulse only after a rising edge of the shared clock and drops it well before the next falling edge, places shared-clock transitions away from sample-clock edges, and freezes the divider with a repeated shift of -1 to force the timeout path.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_COUNT  = 2'd2,
    ST_RESULT = 2'd3
  } spmState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic latchDone;
    logic latchTimeout;
    logic clrResult;
  } spmStrobe_t;
endpackage

// File: rtl/spm_sync2.sv
module spm_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseSync,
  input  logic       syncRise,
  input  logic       trigRise,
  input  logic       cntLast,
  input  logic       readAck,
  output spmStrobe_t stb,
  output logic       armed
);
  spmState_t state;
  spmState_t stateNext;

  always_comb begin
    stateNext = state;
    stb = '0;
    unique case (state)
      ST_ARMED: begin
        if (pulseSync) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (syncRise) begin
          stateNext = ST_COUNT;
          stb.clrCnt = 1'b1;
        end
      end
      ST_COUNT: begin
        if (trigRise) begin
          stateNext = ST_RESULT;
          stb.latchDone = 1'b1;
        end else if (cntLast) begin
          stateNext = ST_RESULT;
          stb.latchTimeout = 1'b1;
        end else begin
          stb.incCnt = 1'b1;
        end
      end
      ST_RESULT: begin
        if (readAck) begin
          stateNext = ST_ARMED;
          stb.clrResult = 1'b1;
        end
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  assign armed = (state == ST_ARMED);
endmodule

// File: rtl/spm_dp.sv
module spm_dp
  import spm_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int SHIFT_W = 4,
  parameter int CNT_W   = $clog2(DIV + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      syncClkSync,
  input  logic                      shiftStb,
  input  logic signed [SHIFT_W-1:0] shiftAmt,
  input  spmStrobe_t                stb,
  output logic                      syncRise,
  output logic                      trigRise,
  output logic                      cntLast,
  output logic                      trigClk,
  output logic                      measDone,
  output logic                      measTimeout,
  output logic [CNT_W-1:0]          measCount
);
  localparam int DW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CNT_W-1:0] DIV_C = CNT_W'(DIV);

  logic [DW-1:0]    divCnt;
  logic [DW-1:0]    divNext;
  logic             trigPrev;
  logic             syncPrev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntInc;

  // divider phase update with optional signed shift, wrapped into 0..DIV-1
  always_comb begin
    int sumI;
    int modI;
    sumI = int'(divCnt) + 1 + (shiftStb ? int'(shiftAmt) : 0);
    modI = sumI % DIV;
    if (modI < 0) modI = modI + DIV;
    divNext = modI[DW-1:0];
  end

  assign trigClk  = (int'(divCnt) < HALF);
  assign trigRise = trigClk & ~trigPrev;
  assign syncRise = syncClkSync & ~syncPrev;
  assign cntInc   = cnt + CNT_W'(1);
  assign cntLast  = (cntInc == DIV_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      trigPrev <= 1'b1;
      syncPrev <= 1'b0;
    end else begin
      divCnt   <= divNext;
      trigPrev <= trigClk;
      syncPrev <= syncClkSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt         <= '0;
      measDone    <= 1'b0;
      measTimeout <= 1'b0;
      measCount   <= '0;
    end else begin
      if (stb.clrCnt)      cnt <= '0;
      else if (stb.incCnt) cnt <= cntInc;
      if (stb.latchDone) begin
        measDone  <= 1'b1;
        measCount <= cntInc;
      end
      if (stb.latchTimeout) begin
        measTimeout <= 1'b1;
        measCount   <= '0;
      end
      if (stb.clrResult) begin
        measDone    <= 1'b0;
        measTimeout <= 1'b0;
        measCount   <= '0;
      end
    end
  end
endmodule

// File: rtl/sync_phase_meter.sv
module sync_phase_meter
  import spm_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int SHIFT_W = 4,
  parameter int CNT_W   = $clog2(DIV + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      syncClkAsync,
  input  logic                      syncPulseAsync,
  input  logic                      shiftStb,
  input  logic signed [SHIFT_W-1:0] shiftAmt,
  input  logic                      readAck,
  output logic                      trigClk,
  output logic                      armed,
  output logic                      measDone,
  output logic                      measTimeout,
  output logic [CNT_W-1:0]          measCount
);
  logic [1:0] syncVec;
  spmStrobe_t stb;
  logic       syncRise;
  logic       trigRise;
  logic       cntLast;

  spm_sync2 #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({syncPulseAsync, syncClkAsync}),
    .syncOut (syncVec)
  );

  spm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pulseSync (syncVec[1]),
    .syncRise  (syncRise),
    .trigRise  (trigRise),
    .cntLast   (cntLast),
    .readAck   (readAck),
    .stb       (stb),
    .armed     (armed)
  );

  spm_dp #(.DIV(DIV), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .syncClkSync (syncVec[0]),
    .shiftStb    (shiftStb),
    .shiftAmt    (shiftAmt),
    .stb         (stb),
    .syncRise    (syncRise),
    .trigRise    (trigRise),
    .cntLast     (cntLast),
    .trigClk     (trigClk),
    .measDone    (measDone),
    .measTimeout (measTimeout),
    .measCount   (measCount)
  );
endmodule

// File: rtl/sync_phase_meter_chk.sv
module sync_phase_meter_chk #(
  parameter int DIV   = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             readAck,
  input logic             armed,
  input logic             measDone,
  input logic             measTimeout,
  input logic [CNT_W-1:0] measCount
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(measDone && measTimeout));

  p_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    measDone |-> (measCount >= CNT_W'(1) && measCount <= CNT_W'(DIV)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && !readAck) |=> (measDone && $stable(measCount)));

  p_timeout_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    measTimeout |-> (measCount == '0));

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((measDone || measTimeout) && readAck) |=> (armed && !measDone && !measTimeout));

  p_armed_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (!measDone && !measTimeout));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((measDone || measTimeout) && !readAck) |=> !armed);
endmodule

bind sync_phase_meter sync_phase_meter_chk #(.DIV(DIV), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .readAck     (readAck),
  .armed       (armed),
  .measDone    (measDone),
  .measTimeout (measTimeout),
  .measCount   (measCount)
);

// File: tb/sync_phase_meter_bench.sv
module sync_phase_meter_bench;
  localparam int DIV     = 8;
  localparam int SHIFT_W = 4;
  localparam int CNT_W   = $clog2(DIV + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncClk = 1'b0;
  logic syncPulse = 1'b0;
  logic shiftStb = 1'b0;
  logic signed [SHIFT_W-1:0] shiftAmt = '0;
  logic readAck = 1'b0;
  logic trigClk, armed, measDone, measTimeout;
  logic [CNT_W-1:0] measCount;

  int testsRun = 0;
  int testsFailed = 0;
  bit running = 1'b0;

  sync_phase_meter #(.DIV(DIV), .SHIFT_W(SHIFT_W)) u_sync_phase_meter (
    .clk(clk), .rstN(rstN), .syncClkAsync(syncClk), .syncPulseAsync(syncPulse),
    .shiftStb(shiftStb), .shiftAmt(shiftAmt), .readAck(readAck),
    .trigClk(trigClk), .armed(armed), .measDone(measDone),
    .measTimeout(measTimeout), .measCount(measCount)
  );

  initial forever #5 clk = ~clk;
  initial begin
    #3;
    forever #50 syncClk = ~syncClk;
  end

  // behavioural reference model
  int mPhase, mState, mCnt, mCount;
  bit mPrevTrig, mDone, mTimeout;
  bit c1, c2, c3, q1, q2;

  function automatic bit modelTrig(int ph);
    return ph < DIV / 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mPrevTrig = 1; mState = 0; mCnt = 0; mCount = 0;
      mDone = 0; mTimeout = 0; c1 = 0; c2 = 0; c3 = 0; q1 = 0; q2 = 0;
    end else begin
      bit curTrig, tRise, sRise;
      int nxt;
      curTrig = modelTrig(mPhase);
      tRise = curTrig && !mPrevTrig;
      sRise = c2 && !c3;
      case (mState)
        0: if (q2) mState = 1;
        1: if (sRise) begin mState = 2; mCnt = 0; end
        2: begin
          if (tRise) begin mState = 3; mDone = 1; mCount = mCnt + 1; end
          else if (mCnt + 1 == DIV) begin mState = 3; mTimeout = 1; mCount = 0; end
          else mCnt = mCnt + 1;
        end
        default: if (readAck) begin mState = 0; mDone = 0; mTimeout = 0; mCount = 0; end
      endcase
      nxt = mPhase + 1 + (shiftStb ? int'(shiftAmt) : 0);
      nxt = ((nxt % DIV) + DIV) % DIV;
      mPrevTrig = curTrig;
      mPhase = nxt;
      c3 = c2; c2 = c1; c1 = syncClk;
      q2 = q1; q1 = syncPulse;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      check(trigClk == modelTrig(mPhase), "R2/R3 trigClk", int'(trigClk), int'(modelTrig(mPhase)));
      check(armed == (mState == 0), "R8 armed", int'(armed), int'(mState == 0));
      check(measDone == mDone, "R6 measDone", int'(measDone), int'(mDone));
      check(measTimeout == mTimeout, "R7 measTimeout", int'(measTimeout), int'(mTimeout));
      check(int'(measCount) == mCount, "R5 measCount", int'(measCount), mCount);
    end
  end

  task automatic sendPulse();
    @(posedge syncClk);
    @(negedge clk);
    syncPulse = 1'b1;
    repeat (2) @(negedge clk);
    syncPulse = 1'b0;
  endtask

  task automatic doShift(input int amt);
    @(negedge clk);
    shiftStb = 1'b1;
    shiftAmt = SHIFT_W'(amt);
    @(negedge clk);
    shiftStb = 1'b0;
    shiftAmt = '0;
  endtask

  task automatic waitResult();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (measDone || measTimeout) break;
    end
  endtask

  task automatic ackResult();
    @(negedge clk);
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
  endtask

  task automatic measureOnce(input string tag);
    sendPulse();
    repeat (2) @(negedge clk);
    check(armed == 1'b0, "R4 armed drops after pulse", int'(armed), 0);
    waitResult();
    check(measDone == 1'b1, {"R5 done ", tag}, int'(measDone), 1);
    check(measCount >= 1 && int'(measCount) <= DIV, {"R5 range ", tag}, int'(measCount), mCount);
    check(!(measDone && measTimeout), "R10 exclusive", int'(measTimeout), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(armed == 1'b1, "R1 armed", int'(armed), 1);
    check(measDone == 1'b0 && measTimeout == 1'b0, "R1 flags", int'(measDone), 0);
    check(measCount == '0, "R1 count", int'(measCount), 0);

    // R8 readAck while armed has no effect
    ackResult();
    @(negedge clk);
    check(armed == 1'b1 && !measDone, "R8 ack while armed", int'(armed), 1);

    measureOnce("default");
    // R9 pulse while result held is ignored
    begin
      int held;
      held = int'(measCount);
      sendPulse();
      repeat (4) @(negedge clk);
      check(int'(measCount) == held && measDone && !armed, "R9 pulse ignored", int'(measCount), held);
    end
    ackResult();
    @(negedge clk);
    check(armed == 1'b1 && !measDone, "R8 rearm after ack", int'(armed), 1);

    doShift(3);
    repeat (5) @(negedge clk);
    measureOnce("shift+3");
    ackResult();
    doShift(-2);
    repeat (3) @(negedge clk);
    measureOnce("shift-2");
    ackResult();
    doShift(7);
    measureOnce("shift+7");
    ackResult();

    // R7 timeout: freeze the divider with a repeated shift of -1
    @(negedge clk);
    shiftStb = 1'b1;
    shiftAmt = -4'sd1;
    sendPulse();
    waitResult();
    check(measTimeout == 1'b1 && !measDone, "R7 timeout", int'(measTimeout), 1);
    check(measCount == '0, "R7 timeout count", int'(measCount), 0);
    shiftStb = 1'b0;
    shiftAmt = '0;
    repeat (3) @(negedge clk);
    check(measTimeout == 1'b1, "R6 timeout held", int'(measTimeout), 1);
    ackResult();
    @(negedge clk);
    check(armed && !measTimeout, "R8 clear timeout", int'(measTimeout), 0);

    measureOnce("after timeout");
    ackResult();
    repeat (10) @(negedge clk);
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule